// File: doc/BRIEF.md
# SPI Word FIFO with Status and Interrupt Logic

This unit sits between a register bus and the serial shifter of an SPI controller. It holds a transmit queue that software fills through the register bus and the shifter drains as a word stream. It also holds a receive queue that the shifter fills as a word stream and software drains through the register bus. Around the two queues it keeps fill levels, programmable thresholds, a five-bit status word, raw and masked interrupt views with a mask, a clear register, one interrupt line and two DMA request levels.

The streams follow valid/ready rules. Toward the shifter, `tx_valid` is high while the transmit queue holds a word, and `tx_data` shows the oldest word. A word leaves the queue on a clock edge where both `tx_valid` and `tx_ready` are high. From the shifter, `rx_ready` is always high, so the shifter is never back-pressured. A word offered with `rx_valid` while the receive queue is full is dropped and recorded as an overflow.

Register reads are combinational on `reg_rdata` in the cycle `reg_rd` is high. Writes take effect at the next clock edge. The only read with a side effect is the receive-data read, which pops one word.

Top module: `spi_fifo_hub`

## Requirements
- R1: Words written to register index 0 leave on `tx_data` in write order. `tx_valid` is high exactly while the transmit queue is non-empty, and a word is removed on each edge with `tx_valid` and `tx_ready` both high.
- R2: `rx_ready` is always high. Each word offered with `rx_valid` into a non-full receive queue is returned, oldest first, by reads of register index 1, and each such read removes one word.
- R3: A write to index 0 while the transmit queue holds DEPTH words leaves the queue unchanged and sets raw interrupt bit 1 (transmit overflow).
- R4: A read of index 1 while the receive queue is empty returns 0, leaves the level at 0 and sets raw interrupt bit 2 (receive underflow).
- R5: A word offered on the receive stream while the receive queue holds DEPTH words is discarded, and raw interrupt bit 3 (receive overflow) is set.
- R6: Index 2 reads the transmit word count and index 3 reads the receive word count, each from 0 to DEPTH.
- R7: Index 6 reads the status word: bit 0 follows the `eng_busy` input, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full. After reset it reads 0x0C.
- R8: The threshold registers (index 4 transmit, index 5 receive) and the DMA level registers (index 12 transmit, index 13 receive) store a written value only if it is below DEPTH. Any other write leaves the old value, which reads back unchanged. All four reset to 0.
- R9: Index 8 reads the raw interrupt word. Bit 0 is high while the transmit count is at or below the transmit threshold, and bit 4 is high while the receive count is above the receive threshold. Both follow the counts with no memory.
- R10: Index 7 is the five-bit mask (reset 0). Index 9 reads raw AND mask, and `irq` is high when any bit of that masked word is high.
- R11: Bits 1 to 3 of the raw word stay set until cleared by a write to index 10. Bit 0 of that write clears all three, bit 1 clears underflow, bit 2 clears receive overflow, and bit 3 clears transmit overflow. If an event and its clear fall in the same cycle, the event wins and the bit stays set.
- R12: Index 11 holds the DMA enables (bit 0 receive, bit 1 transmit). `rx_dma_req` is high while enabled and the receive count is above the receive DMA level. `tx_dma_req` is high while enabled and the transmit count is at or below the transmit DMA level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| tx_valid | output | 1 | Transmit stream holds a word |
| tx_ready | input | 1 | Shifter takes the transmit word |
| tx_data | output | DW | Oldest transmit word |
| rx_valid | input | 1 | Shifter offers a received word |
| rx_ready | output | 1 | Receive stream acceptance, always high |
| rx_data | input | DW | Received word |
| eng_busy | input | 1 | Shifter busy, shown in status bit 0 |
| irq | output | 1 | OR of the masked interrupt word |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |

## Verification
The case most likely to be wrong is a clear-register write that lands in the same cycle as a fresh event for the sticky bit it clears. The bench fills the receive queue to DEPTH and then, at a single edge, offers a word on the receive stream while writing the clear pattern for receive overflow. After that edge, the raw word must still show bit 3 set, and a later lone clear must remove it. A second collision writes the transmit data register on a full queue while the shifter pops. The word must still be dropped and flagged, and the count must fall by one.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

  typedef enum logic [3:0] {
    A_TXDATA = 4'd0,
    A_RXDATA = 4'd1,
    A_TXLVL  = 4'd2,
    A_RXLVL  = 4'd3,
    A_TXTHR  = 4'd4,
    A_RXTHR  = 4'd5,
    A_STAT   = 4'd6,
    A_IMASK  = 4'd7,
    A_IRAW   = 4'd8,
    A_IMSK   = 4'd9,
    A_ICLR   = 4'd10,
    A_DMAEN  = 4'd11,
    A_TXDMA  = 4'd12,
    A_RXDMA  = 4'd13
  } reg_addr_e;

  localparam int IRQ_W = 5;
  localparam int CLR_W = 4;

  // interrupt bit positions
  localparam int IB_TXLOW  = 0;
  localparam int IB_TXOVF  = 1;
  localparam int IB_RXUDF  = 2;
  localparam int IB_RXOVF  = 3;
  localparam int IB_RXHIGH = 4;

  // clear register bit positions
  localparam int CB_ALL   = 0;
  localparam int CB_RXUDF = 1;
  localparam int CB_RXOVF = 2;
  localparam int CB_TXOVF = 3;

  // index of each guarded level register
  localparam int G_TXTHR = 0;
  localparam int G_RXTHR = 1;
  localparam int G_TXDMA = 2;
  localparam int G_RXDMA = 3;
  localparam int G_NUM   = 4;

endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  // full and empty come from the count held before this edge
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push_req && !full;
  assign do_pop  = pop_req && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sfh_limit_reg.sv
module sfh_limit_reg #(
  parameter int DW    = 16,
  parameter int W     = 6,
  parameter int LIMIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  q
);

  logic accept;
  assign accept = we && (32'(wdata) < 32'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (accept) q <= wdata[W-1:0];
  end

endmodule

// File: rtl/sfh_irq.sv
module sfh_irq
  import sfh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_low,
  input  logic             rx_high,
  input  logic             ev_txovf,
  input  logic             ev_rxudf,
  input  logic             ev_rxovf,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);

  logic [2:0] ev, clr, sticky;

  // sticky slot order: transmit overflow, receive underflow, receive overflow
  assign ev  = {ev_rxovf, ev_rxudf, ev_txovf};
  assign clr = {3{clr_we && clr_bits[CB_ALL]}} |
               ({3{clr_we}} & {clr_bits[CB_RXOVF], clr_bits[CB_RXUDF], clr_bits[CB_TXOVF]});

  for (genvar si = 0; si < 3; si++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky[si] <= 1'b0;
      else        sticky[si] <= (sticky[si] && !clr[si]) || ev[si];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  always_comb begin
    raw            = '0;
    raw[IB_TXLOW]  = tx_low;
    raw[IB_TXOVF]  = sticky[0];
    raw[IB_RXUDF]  = sticky[1];
    raw[IB_RXOVF]  = sticky[2];
    raw[IB_RXHIGH] = rx_high;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

endmodule

// File: rtl/spi_fifo_hub.sv
module spi_fifo_hub
  import sfh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          eng_busy,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  reg_addr_e a;
  assign a = reg_addr_e'(reg_addr);

  logic          tx_push, rx_pop;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;

  assign tx_push  = reg_wr && (a == A_TXDATA);
  assign rx_pop   = reg_rd && (a == A_RXDATA);
  assign tx_valid = !tx_empty;
  assign rx_ready = 1'b1;

  sfh_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_req(tx_push), .push_data(reg_wdata),
    .pop_req(tx_ready), .head(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  sfh_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_req(rx_valid), .push_data(rx_data),
    .pop_req(rx_pop), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  // guarded level registers: thresholds and DMA levels
  logic [G_NUM-1:0] g_we;
  logic [CW-1:0]    g_q [G_NUM];

  always_comb begin
    g_we          = '0;
    g_we[G_TXTHR] = reg_wr && (a == A_TXTHR);
    g_we[G_RXTHR] = reg_wr && (a == A_RXTHR);
    g_we[G_TXDMA] = reg_wr && (a == A_TXDMA);
    g_we[G_RXDMA] = reg_wr && (a == A_RXDMA);
  end

  for (genvar gi = 0; gi < G_NUM; gi++) begin : g_lim
    sfh_limit_reg #(.DW(DW), .W(CW), .LIMIT(DEPTH)) u_lim (
      .clk(clk), .rst_n(rst_n), .we(g_we[gi]), .wdata(reg_wdata), .q(g_q[gi])
    );
  end

  logic [1:0] dma_en;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dma_en <= '0;
    else if (reg_wr && (a == A_DMAEN))   dma_en <= reg_wdata[1:0];
  end

  assign tx_dma_req = dma_en[1] && (tx_cnt <= g_q[G_TXDMA]);
  assign rx_dma_req = dma_en[0] && (rx_cnt >  g_q[G_RXDMA]);

  logic [IRQ_W-1:0] irq_raw, irq_mask, irq_masked;

  sfh_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .tx_low(tx_cnt <= g_q[G_TXTHR]),
    .rx_high(rx_cnt > g_q[G_RXTHR]),
    .ev_txovf(tx_push && tx_full),
    .ev_rxudf(rx_pop && rx_empty),
    .ev_rxovf(rx_valid && rx_full),
    .clr_we(reg_wr && (a == A_ICLR)),
    .clr_bits(reg_wdata[CLR_W-1:0]),
    .mask_we(reg_wr && (a == A_IMASK)),
    .mask_wdata(reg_wdata[IRQ_W-1:0]),
    .raw(irq_raw), .mask(irq_mask), .masked(irq_masked), .irq(irq)
  );

  logic [4:0] status;
  assign status = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (a)
        A_RXDATA: reg_rdata = rx_empty ? '0 : rx_head;
        A_TXLVL:  reg_rdata = DW'(tx_cnt);
        A_RXLVL:  reg_rdata = DW'(rx_cnt);
        A_TXTHR:  reg_rdata = DW'(g_q[G_TXTHR]);
        A_RXTHR:  reg_rdata = DW'(g_q[G_RXTHR]);
        A_STAT:   reg_rdata = DW'(status);
        A_IMASK:  reg_rdata = DW'(irq_mask);
        A_IRAW:   reg_rdata = DW'(irq_raw);
        A_IMSK:   reg_rdata = DW'(irq_masked);
        A_DMAEN:  reg_rdata = DW'(dma_en);
        A_TXDMA:  reg_rdata = DW'(g_q[G_TXDMA]);
        A_RXDMA:  reg_rdata = DW'(g_q[G_RXDMA]);
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sfh_checker.sv
module sfh_checker
  import sfh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [3:0]       reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic [CW-1:0]    tx_cnt,
  input logic [CW-1:0]    rx_cnt,
  input logic             tx_full,
  input logic             tx_empty,
  input logic [CW-1:0]    tx_thr,
  input logic [IRQ_W-1:0] irq_raw,
  input logic             rx_dma_req
);

  logic rd_rx, wr_tx, clr_txovf;
  assign rd_rx     = reg_rd && (reg_addr == A_RXDATA);
  assign wr_tx     = reg_wr && (reg_addr == A_TXDATA);
  assign clr_txovf = reg_wr && (reg_addr == A_ICLR) &&
                     (reg_wdata[CB_ALL] || reg_wdata[CB_TXOVF]);

  p_tx_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_cnt == CW'(DEPTH) && !tx_ready) |=> (tx_cnt == CW'(DEPTH) && irq_raw[IB_TXOVF]));

  p_udf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_cnt == '0) |-> (reg_rdata == '0));

  p_udf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_cnt == '0) |=> irq_raw[IB_RXUDF]);

  p_rx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_cnt == CW'(DEPTH) && !rd_rx) |=> (rx_cnt == CW'(DEPTH) && irq_raw[IB_RXOVF]));

  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_full_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  p_thr_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXTHR && 32'(reg_wdata) >= 32'(DEPTH)) |=> $stable(tx_thr));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw[IB_TXOVF] && !clr_txovf) |=> irq_raw[IB_TXOVF]);

  p_rx_dma_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> !rx_dma_req);

endmodule

bind spi_fifo_hub sfh_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .tx_ready(tx_ready), .rx_valid(rx_valid),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_full(tx_full), .tx_empty(tx_empty),
  .tx_thr(g_q[0]), .irq_raw(irq_raw), .rx_dma_req(rx_dma_req)
);

// File: tb/tb_spi_fifo_hub.sv
module tb_spi_fifo_hub;
  import sfh_pkg::*;

  localparam int DW = 16;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, eng_busy = 0;
  logic [DW-1:0] tx_data, rx_data = 0;
  logic irq, tx_dma_req, rx_dma_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fifo_hub #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_busy(eng_busy), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] adr, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = adr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] adr, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = adr;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] adr, input logic [31:0] exp);
    logic [DW-1:0] d;
    rd(adr, d);
    check(tag, $sformatf("reg %0d", adr), 32'(d), exp);
  endtask

  task automatic rx_push(input logic [DW-1:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    check("R7", "status after reset", 32'(0), 32'(0));
    rd_chk("R7", A_STAT, 32'h0C);
    rd_chk("R6", A_TXLVL, 0);
    rd_chk("R6", A_RXLVL, 0);
    rd_chk("R9", A_IRAW, 32'h01);
    check("R10", "irq after reset", 32'(irq), 0);
    check("R1", "tx_valid after reset", 32'(tx_valid), 0);
    check("R2", "rx_ready", 32'(rx_ready), 1);
  endtask

  task automatic t_threshold;
    wr(A_TXTHR, 16'd31);        rd_chk("R8", A_TXTHR, 31);
    wr(A_TXTHR, 16'(DEPTH));    rd_chk("R8", A_TXTHR, 31);
    wr(A_TXTHR, 16'hFFFF);      rd_chk("R8", A_TXTHR, 31);
    wr(A_TXTHR, 16'd4);         rd_chk("R8", A_TXTHR, 4);
  endtask

  task automatic t_tx_path;
    for (int i = 0; i < DEPTH; i++) wr(A_TXDATA, 16'h0100 + 16'(i));
    rd_chk("R6", A_TXLVL, DEPTH);
    rd_chk("R7", A_STAT, 32'h0A);
    rd_chk("R9", A_IRAW, 32'h00);
    wr(A_TXDATA, 16'hDEAD);
    rd_chk("R3", A_TXLVL, DEPTH);
    rd_chk("R3", A_IRAW, 32'h02);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check("R1", "tx_valid during drain", 32'(tx_valid), 1);
      check("R1", "tx order", 32'(tx_data), 32'(16'h0100 + 16'(i)));
      tx_ready = 1;
    end
    @(negedge clk);
    tx_ready = 0;
    check("R1", "tx_valid after drain", 32'(tx_valid), 0);
    wr(A_ICLR, 16'h8);
    rd_chk("R11", A_IRAW, 32'h01);
  endtask

  task automatic t_tx_collide;
    logic [DW-1:0] d;
    for (int i = 0; i < DEPTH; i++) wr(A_TXDATA, 16'h0500 + 16'(i));
    @(negedge clk);
    reg_wr = 1; reg_addr = A_TXDATA; reg_wdata = 16'hBEEF; tx_ready = 1;
    @(negedge clk);
    reg_wr = 0; tx_ready = 0;
    rd(A_TXLVL, d);
    check("R3", "level after full write with pop", 32'(d), DEPTH - 1);
    rd_chk("R3", A_IRAW, 32'h02);
    tx_ready = 1;
    repeat (DEPTH) @(negedge clk);
    tx_ready = 0;
    check("R1", "tx drained", 32'(tx_valid), 0);
    wr(A_ICLR, 16'h1);
  endtask

  task automatic t_rx_path;
    wr(A_RXTHR, 16'd2);
    for (int i = 0; i < 3; i++) rx_push(16'h0200 + 16'(i));
    rd_chk("R6", A_RXLVL, 3);
    rd_chk("R9", A_IRAW, 32'h11);
    for (int i = 0; i < 3; i++) rd_chk("R2", A_RXDATA, 32'h0200 + i);
    rd_chk("R4", A_RXDATA, 0);
    rd_chk("R4", A_RXLVL, 0);
    rd_chk("R4", A_IRAW, 32'h05);
    wr(A_ICLR, 16'h2);
    rd_chk("R11", A_IRAW, 32'h01);
  endtask

  task automatic t_rx_overflow;
    for (int i = 0; i <= DEPTH; i++) rx_push(16'h0300 + 16'(i));
    rd_chk("R5", A_RXLVL, DEPTH);
    rd_chk("R5", A_IRAW, 32'h19);
    rd_chk("R7", A_STAT, 32'h14);
    wr(A_ICLR, 16'h1);
    rd_chk("R11", A_IRAW, 32'h11);
    // clear and new overflow at the same edge: event wins
    @(negedge clk);
    rx_valid = 1; rx_data = 16'hFACE;
    reg_wr = 1; reg_addr = A_ICLR; reg_wdata = 16'h4;
    @(negedge clk);
    rx_valid = 0; reg_wr = 0;
    rd_chk("R11", A_IRAW, 32'h19);
    wr(A_ICLR, 16'h4);
    rd_chk("R11", A_IRAW, 32'h11);
    rd_chk("R5", A_RXDATA, 32'h0300);
    for (int i = 1; i < DEPTH; i++) begin
      logic [DW-1:0] d;
      rd(A_RXDATA, d);
      if (i == DEPTH - 1) check("R5", "last kept word", 32'(d), 32'h0300 + DEPTH - 1);
    end
    rd_chk("R6", A_RXLVL, 0);
  endtask

  task automatic t_mask;
    wr(A_IMASK, 16'h01);
    rd_chk("R10", A_IMASK, 32'h01);
    @(negedge clk); check("R10", "irq with tx-low unmasked", 32'(irq), 1);
    rd_chk("R10", A_IMSK, 32'h01);
    wr(A_IMASK, 16'h1E);
    @(negedge clk); check("R10", "irq masked off", 32'(irq), 0);
    rd_chk("R4", A_RXDATA, 0);
    rd_chk("R10", A_IMSK, 32'h04);
    @(negedge clk); check("R10", "irq on underflow", 32'(irq), 1);
    wr(A_ICLR, 16'h1);
    @(negedge clk); check("R11", "irq after clear", 32'(irq), 0);
    wr(A_IMASK, 16'h0);
  endtask

  task automatic t_dma;
    @(negedge clk);
    check("R12", "tx dma disabled", 32'(tx_dma_req), 0);
    wr(A_RXDMA, 16'd1);
    wr(A_RXDMA, 16'd40);
    rd_chk("R8", A_RXDMA, 1);
    wr(A_DMAEN, 16'h3);
    rd_chk("R12", A_DMAEN, 3);
    @(negedge clk);
    check("R12", "tx dma at level 0", 32'(tx_dma_req), 1);
    check("R12", "rx dma empty", 32'(rx_dma_req), 0);
    rx_push(16'h0A); rx_push(16'h0B);
    @(negedge clk);
    check("R12", "rx dma above level", 32'(rx_dma_req), 1);
    wr(A_TXDATA, 16'h0C);
    @(negedge clk);
    check("R12", "tx dma above level", 32'(tx_dma_req), 0);
    wr(A_DMAEN, 16'h0);
    @(negedge clk);
    check("R12", "rx dma disabled", 32'(rx_dma_req), 0);
  endtask

  task automatic t_busy;
    eng_busy = 1;
    rd_chk("R7", A_STAT, 32'h01);
    eng_busy = 0;
    rd_chk("R7", A_STAT, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_threshold();
    t_tx_path();
    t_tx_collide();
    t_rx_path();
    t_rx_overflow();
    t_mask();
    t_dma();
    t_busy();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule